// File: doc/BRIEF.md
# Range-Based Memory Protection Buffer

This block is a small, fully associative store of protection entries that rules on every memory reference. Each entry names one accessing protection domain by its virtual address, a region of virtual addresses, and a four-bit set of rights. A region is given by a match mask and a don't-care mask. It may be non-contiguous and may have any size, so it is not tied to a page.

On each lookup the block compares the current virtual address, the attempted access type and the two domain base registers (general and carrier) against all valid entries at once. One cycle later it reports exactly one of allow, deny or miss. Outside logic reacts to a miss by fetching the entry from memory and writing it through the refill port. The refill port reduces the two masks to a stored range mask when the entry is written. New entries go to the slot named by a round-robin pointer. A single invalidate input empties the buffer.

Top module: `region_guard_buf`

## Requirements
- R1: After reset every entry is invalid, the replacement pointer is at slot 0, and all three result outputs are low. A lookup made just after reset reports miss.
- R2: An address lies in an entry's region when every bit that is clear in the don't-care mask equals the corresponding match-mask bit. With match 0x0C80 and don't-care 0x017F on 16 bits, the region covers exactly 0x0C80–0x0CFF and 0x0D80–0x0DFF.
- R3: The range mask is formed when the entry is written and is kept in the entry. Match-mask bits that sit under don't-care bits have no effect on which addresses hit.
- R4: An entry whose carrier flag is 1 compares its domain against the carrier base register. An entry whose flag is 0 compares against the general base register. A hit needs both the domain and the region to match.
- R5: Rights and access-type bits are laid out as bit 0 read, bit 1 write, bit 2 execute, bit 3 switch. A hitting lookup gives allow when every bit set in the access type is also set in the entry's rights.
- R6: A hitting lookup whose type asks for a right the entry lacks gives deny, never miss.
- R7: A lookup that hits no valid entry gives miss alone, with allow and deny low.
- R8: Results are registered and appear on the clock edge after the cycle in which the lookup is presented. A cycle with no lookup leaves all three outputs low on the next edge.
- R9: Refill writes fill slots 0, 1, … DEPTH-1 in turn and then wrap, so write DEPTH+1 replaces the entry from the first write.
- R10: The invalidate input clears every valid bit and returns the pointer to slot 0. If it arrives in the same cycle as a refill write, the write is dropped.
- R11: If more than one entry hits, the lowest-numbered hitting slot decides allow or deny.
- R12: A lookup made in the same cycle as a refill write is judged against the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | AW | Current virtual address |
| lk_type | input | 4 | Attempted access type (read, write, execute, switch) |
| gen_dom | input | AW | General domain base register |
| car_dom | input | AW | Carrier domain base register |
| rf_we | input | 1 | Refill write strobe |
| rf_dom | input | AW | Accessing domain name for the new entry |
| rf_carrier | input | 1 | New entry belongs to a carrier domain |
| rf_match | input | AW | Region match mask |
| rf_dontcare | input | AW | Region don't-care mask |
| rf_rights | input | 4 | Granted rights |
| lk_allow | output | 1 | Lookup permitted |
| lk_deny | output | 1 | Lookup hit but rights insufficient |
| lk_miss | output | 1 | No entry matched |

## Verification
Embedded assertions check, on every cycle, that each lookup yields exactly one verdict and that idle cycles yield none. They also check that a lookup with no hitting slot reports miss, that an invalidate leaves no valid slot, and that the slot under the pointer becomes valid after a write. Region shape, domain selection, rights coverage, lowest-slot priority, round-robin order and same-cycle write ordering can only be shown by the bench. It does this by comparing the verdicts against a bench-side model under directed mask cases and random refill and lookup traffic.

// File: rtl/rgb_pkg.sv
package rgb_pkg;
  localparam int RIGHTS_W = 4;
  localparam int RT_READ   = 0;
  localparam int RT_WRITE  = 1;
  localparam int RT_EXEC   = 2;
  localparam int RT_SWITCH = 3;

  typedef logic [RIGHTS_W-1:0] rights_t;

  // every requested right must be granted
  function automatic logic rights_cover(rights_t granted, rights_t asked);
    return (asked & ~granted) == '0;
  endfunction
endpackage

// File: rtl/rgb_entry.sv
module rgb_entry
  import rgb_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [AW-1:0] ld_dom,
  input  logic          ld_carrier,
  input  logic [AW-1:0] ld_match,
  input  logic [AW-1:0] ld_dontcare,
  input  rights_t       ld_rights,
  input  logic [AW-1:0] q_addr,
  input  logic [AW-1:0] q_gen_dom,
  input  logic [AW-1:0] q_car_dom,
  output logic          valid,
  output logic          hit,
  output rights_t       rights
);
  logic [AW-1:0] dom_r, care_r, key_r;
  logic          car_r;
  logic          region_hit, dom_hit;
  logic [AW-1:0] active_dom;

  // bits that must compare
  function automatic logic [AW-1:0] care_bits(logic [AW-1:0] dc);
    return ~dc;
  endfunction

  // canonical key: match with wildcards zeroed
  function automatic logic [AW-1:0] region_key(logic [AW-1:0] m, logic [AW-1:0] dc);
    return m & ~dc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      dom_r  <= '0;
      care_r <= '0;
      key_r  <= '0;
      car_r  <= 1'b0;
      rights <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      dom_r  <= ld_dom;
      car_r  <= ld_carrier;
      care_r <= care_bits(ld_dontcare);
      key_r  <= region_key(ld_match, ld_dontcare);
      rights <= ld_rights;
    end
  end

  assign region_hit = ((q_addr ^ key_r) & care_r) == '0;
  assign active_dom = car_r ? q_car_dom : q_gen_dom;
  assign dom_hit    = active_dom == dom_r;
  assign hit        = valid && region_hit && dom_hit;

  // R10
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !valid);

  // R9
  load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> valid);
endmodule

// File: rtl/rgb_victim.sv
module rgb_victim #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [PW-1:0]    ptr,
  output logic [DEPTH-1:0] sel
);
  function automatic logic [PW-1:0] next_slot(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) ptr <= '0;
    else if (adv)        ptr <= next_slot(ptr);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel[i] = ptr == PW'(i);
  end

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel));
endmodule

// File: rtl/rgb_resolve.sv
module rgb_resolve
  import rgb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] hits,
  input  rights_t          slot_rights [DEPTH],
  input  rights_t          ask,
  output logic             any_hit,
  output logic             permit
);
  rights_t winner;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    winner = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hits[i]) winner = slot_rights[i];
    end
  end

  assign any_hit = |hits;
  assign permit  = rights_cover(winner, ask);
endmodule

// File: rtl/region_guard_buf.sv
module region_guard_buf
  import rgb_pkg::*;
#(
  parameter int AW    = 64,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic [3:0]    lk_type,
  input  logic [AW-1:0] gen_dom,
  input  logic [AW-1:0] car_dom,
  input  logic          rf_we,
  input  logic [AW-1:0] rf_dom,
  input  logic          rf_carrier,
  input  logic [AW-1:0] rf_match,
  input  logic [AW-1:0] rf_dontcare,
  input  logic [3:0]    rf_rights,
  output logic          lk_allow,
  output logic          lk_deny,
  output logic          lk_miss
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             refill_go;
  logic [PW-1:0]    wr_ptr;
  logic [DEPTH-1:0] wr_sel;
  logic [DEPTH-1:0] slot_valid;
  logic [DEPTH-1:0] slot_hit;
  rights_t          slot_rights [DEPTH];
  logic             any_hit, permit;

  assign refill_go = rf_we && !flush;

  rgb_victim #(.DEPTH(DEPTH)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush),
    .adv   (refill_go),
    .ptr   (wr_ptr),
    .sel   (wr_sel)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rgb_entry #(.AW(AW)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (flush),
      .load        (refill_go && wr_sel[i]),
      .ld_dom      (rf_dom),
      .ld_carrier  (rf_carrier),
      .ld_match    (rf_match),
      .ld_dontcare (rf_dontcare),
      .ld_rights   (rf_rights),
      .q_addr      (lk_addr),
      .q_gen_dom   (gen_dom),
      .q_car_dom   (car_dom),
      .valid       (slot_valid[i]),
      .hit         (slot_hit[i]),
      .rights      (slot_rights[i])
    );
  end

  rgb_resolve #(.DEPTH(DEPTH)) u_resolve (
    .hits        (slot_hit),
    .slot_rights (slot_rights),
    .ask         (lk_type),
    .any_hit     (any_hit),
    .permit      (permit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_allow <= 1'b0;
      lk_deny  <= 1'b0;
      lk_miss  <= 1'b0;
    end else begin
      lk_allow <= lk_valid && any_hit && permit;
      lk_deny  <= lk_valid && any_hit && !permit;
      lk_miss  <= lk_valid && !any_hit;
    end
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !(lk_allow || lk_deny || lk_miss));

  // R6
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> $countones({lk_allow, lk_deny, lk_miss}) == 1);

  // R7
  miss_without_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && slot_hit == '0) |=> lk_miss);

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> slot_valid == '0);

  // R9
  refill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_go |=> slot_valid[$past(wr_ptr)]);
endmodule

// File: tb/tb_region_guard_buf.sv
module tb_region_guard_buf;
  localparam int AW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, flush, lk_valid, rf_we, rf_carrier;
  logic [AW-1:0] lk_addr, gen_dom, car_dom, rf_dom, rf_match, rf_dontcare;
  logic [3:0] lk_type, rf_rights;
  logic lk_allow, lk_deny, lk_miss;

  region_guard_buf #(.AW(AW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_type(lk_type), .gen_dom(gen_dom), .car_dom(car_dom),
    .rf_we(rf_we), .rf_dom(rf_dom), .rf_carrier(rf_carrier), .rf_match(rf_match),
    .rf_dontcare(rf_dontcare), .rf_rights(rf_rights),
    .lk_allow(lk_allow), .lk_deny(lk_deny), .lk_miss(lk_miss)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  bit          m_v   [DEPTH];
  logic [AW-1:0] m_dom [DEPTH];
  logic [AW-1:0] m_mt  [DEPTH];
  logic [AW-1:0] m_dc  [DEPTH];
  bit          m_car [DEPTH];
  logic [3:0]  m_rt  [DEPTH];
  int          m_ptr = 0;

  localparam logic [AW-1:0] GD = 16'h1000, GD2 = 16'h1111, CD = 16'h2000;

  // bit-by-bit membership test
  function automatic bit in_region(logic [AW-1:0] a, logic [AW-1:0] mt, logic [AW-1:0] dc);
    for (int b = 0; b < AW; b++)
      if (!dc[b] && (a[b] != mt[b])) return 0;
    return 1;
  endfunction

  // returns {allow, deny, miss}
  function automatic logic [2:0] expect_v(logic [AW-1:0] a, logic [3:0] t,
                                          logic [AW-1:0] g, logic [AW-1:0] c);
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && in_region(a, m_mt[i], m_dc[i]) && ((m_car[i] ? c : g) == m_dom[i])) begin
        for (int b = 0; b < 4; b++)
          if (t[b] && !m_rt[i][b]) return 3'b010;
        return 3'b100;
      end
    end
    return 3'b001;
  endfunction

  task automatic check3(logic [2:0] exp, string tag);
    n_vec++;
    if ({lk_allow, lk_deny, lk_miss} !== exp) begin
      n_bad++;
      $display("FAIL %s: got a/d/m=%b expected %b", tag,
               {lk_allow, lk_deny, lk_miss}, exp);
    end
  endtask

  task automatic step(bit lv, logic [AW-1:0] a, logic [3:0] t, logic [AW-1:0] g,
                      logic [AW-1:0] c, bit we, logic [AW-1:0] d, bit car,
                      logic [AW-1:0] mt, logic [AW-1:0] dc, logic [3:0] rt,
                      bit fl, string tag);
    logic [2:0] exp;
    @(negedge clk);
    lk_valid = lv; lk_addr = a; lk_type = t; gen_dom = g; car_dom = c;
    rf_we = we; rf_dom = d; rf_carrier = car; rf_match = mt; rf_dontcare = dc;
    rf_rights = rt; flush = fl;
    exp = lv ? expect_v(a, t, g, c) : 3'b000;
    @(posedge clk);
    #1;
    check3(exp, tag);
    if (fl) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (we) begin
      m_v[m_ptr] = 1; m_dom[m_ptr] = d; m_car[m_ptr] = car;
      m_mt[m_ptr] = mt; m_dc[m_ptr] = dc; m_rt[m_ptr] = rt;
      m_ptr = (m_ptr + 1) % DEPTH;
    end
  endtask

  task automatic look(logic [AW-1:0] a, logic [3:0] t, logic [AW-1:0] g,
                      logic [AW-1:0] c, string tag);
    step(1, a, t, g, c, 0, '0, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic put(logic [AW-1:0] d, bit car, logic [AW-1:0] mt,
                     logic [AW-1:0] dc, logic [3:0] rt, string tag);
    step(0, '0, '0, GD, CD, 1, d, car, mt, dc, rt, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_dom[i] = '0; m_mt[i] = '0; m_dc[i] = '0; m_car[i] = 0; m_rt[i] = '0;
    end
    rst_n = 0; flush = 0; lk_valid = 0; rf_we = 0; rf_carrier = 0;
    lk_addr = '0; lk_type = '0; gen_dom = GD; car_dom = CD;
    rf_dom = '0; rf_match = '0; rf_dontcare = '0; rf_rights = '0;
    repeat (3) @(posedge clk);
    #1;
    check3(3'b000, "R1 reset outputs");
    @(negedge clk); rst_n = 1;

    look(16'h0C80, 4'b0001, GD, CD, "R1 empty buffer misses");
    // R2 example region, rights read+write
    put(GD, 0, 16'h0C80, 16'h017F, 4'b0011, "R2 write");
    look(16'h0C80, 4'b0001, GD, CD, "R2 low edge");
    look(16'h0CFF, 4'b0001, GD, CD, "R2 top of first block");
    look(16'h0D80, 4'b0001, GD, CD, "R2 second block");
    look(16'h0DFF, 4'b0001, GD, CD, "R2 top of second block");
    look(16'h0C7F, 4'b0001, GD, CD, "R2 below region");
    look(16'h0D00, 4'b0001, GD, CD, "R2 gap");
    look(16'h0E00, 4'b0001, GD, CD, "R2 above region");
    look(16'h0C00, 4'b0001, GD, CD, "R2 cared bit7 clear");
    // R3 match bits under don't-care ignored
    put(GD2, 0, 16'h4FFF, 16'h00FF, 4'b0100, "R3 write");
    look(16'h4F00, 4'b0100, GD2, CD, "R3 wildcard match bits ignored");
    look(16'h4E00, 4'b0100, GD2, CD, "R3 cared bit differs");
    // R5 / R6
    look(16'h0C90, 4'b0010, GD, CD, "R5 write allowed");
    look(16'h0C90, 4'b0011, GD, CD, "R5 read+write allowed");
    look(16'h0C90, 4'b0100, GD, CD, "R6 execute denied");
    look(16'h0C90, 4'b1000, GD, CD, "R6 switch denied");
    // R4 carrier selection
    put(CD, 1, 16'h8000, 16'h0FFF, 4'b1000, "R4 write");
    look(16'h8123, 4'b1000, GD, CD, "R4 carrier entry uses carrier reg");
    look(16'h8123, 4'b1000, CD, GD, "R4 carrier entry ignores general reg");
    look(16'h0C80, 4'b0001, CD, GD, "R4 general entry ignores carrier reg");
    // R8 idle
    step(0, 16'h0C80, 4'b0001, GD, CD, 0, '0, 0, '0, '0, '0, 0, "R8 idle quiet");
    // R11 overlapping slot 3 with execute
    put(GD, 0, 16'h0C80, 16'h00FF, 4'b0100, "R11 write");
    look(16'h0CA0, 4'b0100, GD, CD, "R11 lowest slot decides");
    look(16'h0C10, 4'b0100, GD, CD, "R11 only higher slot hits");
    // R12 same-cycle write and lookup
    step(1, 16'h9005, 4'b0001, GD, CD, 1, GD, 0, 16'h9000, 16'h000F, 4'b0001, 0,
         "R12 lookup sees old contents");
    look(16'h9005, 4'b0001, GD, CD, "R12 visible next cycle");
    // R9 fill and wrap
    put(GD, 0, 16'hB000, 16'h000F, 4'b0001, "R9 slot5");
    put(GD, 0, 16'hB100, 16'h000F, 4'b0001, "R9 slot6");
    put(GD, 0, 16'hB200, 16'h000F, 4'b0001, "R9 slot7");
    put(GD, 0, 16'hA000, 16'h00FF, 4'b0001, "R9 wrap to slot0");
    look(16'h0D80, 4'b0001, GD, CD, "R9 first entry replaced");
    look(16'h0C80, 4'b0001, GD, CD, "R9 surviving overlap denies");
    look(16'hA010, 4'b0001, GD, CD, "R9 new entry hits");
    look(16'hB105, 4'b0001, GD, CD, "R9 slot6 kept");
    // R10 flush beats write
    step(0, '0, '0, GD, CD, 1, GD, 0, 16'hC000, 16'h00FF, 4'b0001, 1, "R10 flush");
    look(16'hA010, 4'b0001, GD, CD, "R10 flushed entry misses");
    look(16'hC010, 4'b0001, GD, CD, "R10 dropped write misses");

    // random traffic
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] doms [4];
      logic [AW-1:0] a, g, c;
      int k;
      doms[0] = GD; doms[1] = GD2; doms[2] = CD; doms[3] = 16'h3333;
      k = $urandom_range(DEPTH - 1);
      a = (m_mt[k] & ~m_dc[k]) | (16'($urandom) & m_dc[k]);
      if ($urandom_range(7) == 0) a = a ^ (16'h1 << $urandom_range(AW - 1));
      g = doms[$urandom_range(3)];
      c = ($urandom_range(3) == 0) ? doms[$urandom_range(3)] : m_dom[k];
      if (!m_car[k] && $urandom_range(1)) g = m_dom[k];
      step($urandom_range(4) != 0, a, 4'($urandom), g, c,
           $urandom_range(3) == 0, doms[$urandom_range(3)], 1'($urandom),
           16'($urandom), 16'($urandom) | 16'($urandom), 4'($urandom),
           $urandom_range(150) == 0, "R5 R7 R11 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule